// File: doc/BRIEF.md
# Pseudo-random bit sequence checker with synchronization tracking

The block checks a serial bit stream that should carry one of three maximal-length pseudo-random sequences. While it is hunting for the sequence, it feeds received bits into a local shift register and uses that register to predict each next bit. After a long enough run of correct predictions, it declares synchronization. From then on the shift register runs on its own predictions. Each received bit that disagrees with the prediction is reported as a bit error.

If too many errors land inside one fixed-length window, the checker drops synchronization and starts hunting again. Two sticky event flags record bit errors and changes of the synchronization state. Each flag has its own interrupt enable, and software clears a flag by writing a one to it. An optional inversion is applied to the received data before the check.

The data input is a valid/ready stream of one bit per beat. The block never applies back-pressure: `s_ready` is held at 1, and a bit is consumed on every clock edge where `s_valid` is 1. Control and status pins are plain levels.

Top module: `prbs_chk`

## Requirements
- R1: `s_ready` is always 1. A bit is consumed only on an edge where `s_valid` and `test_en` are both 1. While `test_en` is 0, `in_sync` is 0, no error pulse is produced and all checking state is cleared, so every 0-to-1 change of `test_en` starts acquisition from an empty history.
- R2: `pat_sel` picks the recurrence, where b[n] is the received bit n:
  - 2'b00: b[n] = b[n-9] ^ b[n-11]
  - 2'b01: b[n] = b[n-14] ^ b[n-15]
  - 2'b10 and 2'b11: b[n] = b[n-17] ^ b[n-20]
- R3: While out of sync, received bits are shifted into the history. `in_sync` rises on the edge of the 48th consecutive consumed bit that equals its prediction, and any mismatch restarts that run.
- R4: While in sync, each consumed bit that differs from its prediction makes `err_pulse` high for exactly the following clock cycle and sets `err_flag`. Mismatches while out of sync produce neither.
- R5: While in sync, the history shifts in predicted bits, so an isolated received error causes exactly one error event.
- R6: While in sync, the 11th error inside one 48-bit window clears `in_sync` on the edge of that bit. Ten errors in a window keep sync.
- R7: Windows do not overlap. The first window starts with the first bit consumed after `in_sync` rises, and the error count restarts every 48 in-sync bits.
- R8: Every change of `in_sync`, rising or falling, including a fall caused by `test_en` going low, sets `chg_flag` on the same edge.
- R9: A 1 on `clr_err` or `clr_chg` clears the matching flag at the next edge. An event on that same edge leaves the flag set.
- R10: `irq` = (`err_flag` & `err_irq_en`) | (`chg_flag` & `chg_irq_en`), with no clock delay.
- R11: When `rx_inv` is 1, each received bit is inverted before prediction and comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Received bit is present |
| s_ready | output | 1 | Always 1: the block accepts a bit every cycle |
| s_data | input | 1 | Received serial bit |
| test_en | input | 1 | Checking enable; a rise restarts acquisition |
| pat_sel | input | 2 | Sequence select (see R2) |
| rx_inv | input | 1 | Invert received bits before checking |
| err_irq_en | input | 1 | Interrupt enable for the bit-error flag |
| chg_irq_en | input | 1 | Interrupt enable for the sync-change flag |
| clr_err | input | 1 | Write-one-to-clear strobe for `err_flag` |
| clr_chg | input | 1 | Write-one-to-clear strobe for `chg_flag` |
| in_sync | output | 1 | Synchronized status |
| err_pulse | output | 1 | One-cycle pulse per in-sync bit error |
| err_flag | output | 1 | Sticky bit-error flag |
| chg_flag | output | 1 | Sticky sync-change flag |
| irq | output | 1 | Interrupt request |

## Verification
Some internal faults show up at the ports quickly:
- A wrong tap or history fault stops `in_sync` from ever rising on a clean sequence, or causes a burst of `err_pulse` right after lock. Either appears within about 70 bits.
- A wrong acquisition run length moves the `in_sync` rise away from the exact 48th bit of an all-zero stream.

Other faults need placed errors to expose them:
- A window counter that is misaligned or overlapping shows up with ten errors placed either side of a window boundary.
- An error limit that is off by one shows up with exactly ten and then eleven errors inside one window.

Errors are injected at known window positions, and sync loss is then visible on the very bit where it is due. Faults in flag set or clear priority appear on `irq` in the cycle after the strobe.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int HIST_W  = 20;
  localparam int NUM_PAT = 4;

  typedef enum logic [1:0] {
    PAT_P11  = 2'b00,
    PAT_P15  = 2'b01,
    PAT_P20  = 2'b10,
    PAT_P20B = 2'b11
  } pat_sel_e;

  // History bit k holds the bit received k+1 steps ago.
  function automatic logic [HIST_W-1:0] tap_mask(input int p);
    logic [HIST_W-1:0] m;
    m = '0;
    case (p)
      0:       begin m[8]  = 1'b1; m[10] = 1'b1; end
      1:       begin m[13] = 1'b1; m[14] = 1'b1; end
      default: begin m[16] = 1'b1; m[19] = 1'b1; end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/prbs_predict.sv
module prbs_predict
  import prbs_chk_pkg::*;
(
  input  logic [HIST_W-1:0] hist,
  input  logic [1:0]        pat_sel,
  output logic              pred
);

  logic [NUM_PAT-1:0] cand;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    localparam logic [HIST_W-1:0] MASK = tap_mask(p);
    assign cand[p] = ^(hist & MASK);
  end

  assign pred = cand[pat_sel];

endmodule

// File: rtl/prbs_sync_fsm.sv
module prbs_sync_fsm
  import prbs_chk_pkg::*;
#(
  parameter int LOCK_RUN  = 48,
  parameter int WIN_LEN   = 48,
  parameter int ERR_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              bit_vld,
  input  logic              rx_bit,
  input  logic              pred,
  output logic [HIST_W-1:0] hist,
  output logic              sync_o,
  output logic              err_evt,
  output logic              chg_evt,
  output logic              err_pulse_o
);

  localparam int RUN_W = (LOCK_RUN > 1) ? $clog2(LOCK_RUN) : 1;
  localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int ERR_W = $clog2(ERR_LIMIT + 2);

  logic [HIST_W-1:0] hist_q, hist_n;
  logic [RUN_W-1:0]  run_q, run_n;
  logic [WIN_W-1:0]  win_q, win_n;
  logic [ERR_W-1:0]  errc_q, errc_n, err_tot;
  logic              sync_q, sync_n, mism, pulse_q;

  assign mism    = rx_bit ^ pred;
  assign err_tot = errc_q + {{(ERR_W-1){1'b0}}, mism};

  always_comb begin
    hist_n  = hist_q;
    run_n   = run_q;
    win_n   = win_q;
    errc_n  = errc_q;
    sync_n  = sync_q;
    err_evt = 1'b0;
    if (!enable) begin
      hist_n = '0;
      run_n  = '0;
      win_n  = '0;
      errc_n = '0;
      sync_n = 1'b0;
    end else if (bit_vld) begin
      if (!sync_q) begin
        hist_n = {hist_q[HIST_W-2:0], rx_bit};
        if (mism) begin
          run_n = '0;
        end else if (run_q == RUN_W'(LOCK_RUN - 1)) begin
          sync_n = 1'b1;
          run_n  = '0;
          win_n  = '0;
          errc_n = '0;
        end else begin
          run_n = run_q + RUN_W'(1);
        end
      end else begin
        hist_n  = {hist_q[HIST_W-2:0], pred};
        err_evt = mism;
        if (err_tot > ERR_W'(ERR_LIMIT)) begin
          sync_n = 1'b0;
          run_n  = '0;
          win_n  = '0;
          errc_n = '0;
        end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
          win_n  = '0;
          errc_n = '0;
        end else begin
          win_n  = win_q + WIN_W'(1);
          errc_n = err_tot;
        end
      end
    end
  end

  assign chg_evt = sync_n ^ sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      run_q   <= '0;
      win_q   <= '0;
      errc_q  <= '0;
      sync_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      hist_q  <= hist_n;
      run_q   <= run_n;
      win_q   <= win_n;
      errc_q  <= errc_n;
      sync_q  <= sync_n;
      pulse_q <= err_evt;
    end
  end

  assign hist        = hist_q;
  assign sync_o      = sync_q;
  assign err_pulse_o = pulse_q;

  assert_err_only_in_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(sync_q));

  assert_lock_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_q) |-> ($past(run_q) == RUN_W'(LOCK_RUN - 1)) && $past(bit_vld));

  assert_err_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> (errc_q <= ERR_W'(ERR_LIMIT)));

  assert_win_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= WIN_W'(WIN_LEN - 1));

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (!sync_q && !pulse_q));

endmodule

// File: rtl/prbs_event_flags.sv
module prbs_event_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic chg_evt,
  input  logic sync_i,
  input  logic err_pulse_i,
  input  logic clr_err,
  input  logic clr_chg,
  input  logic err_irq_en,
  input  logic chg_irq_en,
  output logic err_flag,
  output logic chg_flag,
  output logic irq
);

  logic err_q, chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      if (err_evt)      err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
      if (chg_evt)      chg_q <= 1'b1;
      else if (clr_chg) chg_q <= 1'b0;
    end
  end

  assign err_flag = err_q;
  assign chg_flag = chg_q;
  assign irq      = (err_q & err_irq_en) | (chg_q & chg_irq_en);

  assert_chg_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i != $past(sync_i)) |-> chg_q);

  assert_pulse_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse_i |-> err_q);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(clr_err));

  assert_chg_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chg_q) |-> $past(clr_chg));

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_chk_pkg::*;
#(
  parameter int LOCK_RUN  = 48,
  parameter int WIN_LEN   = 48,
  parameter int ERR_LIMIT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic       s_data,
  input  logic       test_en,
  input  logic [1:0] pat_sel,
  input  logic       rx_inv,
  input  logic       err_irq_en,
  input  logic       chg_irq_en,
  input  logic       clr_err,
  input  logic       clr_chg,
  output logic       in_sync,
  output logic       err_pulse,
  output logic       err_flag,
  output logic       chg_flag,
  output logic       irq
);

  logic [HIST_W-1:0] hist;
  logic              pred, rx_bit, err_evt, chg_evt;

  assign s_ready = 1'b1;
  assign rx_bit  = s_data ^ rx_inv;

  prbs_predict i_predict (
    .hist    (hist),
    .pat_sel (pat_sel),
    .pred    (pred)
  );

  prbs_sync_fsm #(
    .LOCK_RUN  (LOCK_RUN),
    .WIN_LEN   (WIN_LEN),
    .ERR_LIMIT (ERR_LIMIT)
  ) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (test_en),
    .bit_vld     (s_valid),
    .rx_bit      (rx_bit),
    .pred        (pred),
    .hist        (hist),
    .sync_o      (in_sync),
    .err_evt     (err_evt),
    .chg_evt     (chg_evt),
    .err_pulse_o (err_pulse)
  );

  prbs_event_flags i_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .err_evt     (err_evt),
    .chg_evt     (chg_evt),
    .sync_i      (in_sync),
    .err_pulse_i (err_pulse),
    .clr_err     (clr_err),
    .clr_chg     (clr_chg),
    .err_irq_en  (err_irq_en),
    .chg_irq_en  (chg_irq_en),
    .err_flag    (err_flag),
    .chg_flag    (chg_flag),
    .irq         (irq)
  );

endmodule

// File: tb/test_prbs_chk.sv
`timescale 1ns/1ps
module test_prbs_chk;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0, s_data = 1'b0, test_en = 1'b0, rx_inv = 1'b0;
  logic [1:0] pat_sel = 2'b00;
  logic       err_irq_en = 1'b0, chg_irq_en = 1'b0, clr_err = 1'b0, clr_chg = 1'b0;
  logic       s_ready, in_sync, err_pulse, err_flag, chg_flag, irq;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int pos    = 0;
  logic [19:0] g;

  always #10 clk = ~clk;

  prbs_chk i_prbs_chk (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .test_en(test_en), .pat_sel(pat_sel), .rx_inv(rx_inv), .err_irq_en(err_irq_en),
    .chg_irq_en(chg_irq_en), .clr_err(clr_err), .clr_chg(clr_chg), .in_sync(in_sync),
    .err_pulse(err_pulse), .err_flag(err_flag), .chg_flag(chg_flag), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic d);
    logic was;
    was = in_sync;
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = d;
    @(posedge clk);
    #2;
    s_valid = 1'b0;
    if (err_pulse) pulses++;
    if (!was && in_sync) pos = 0;
    else if (was) pos = (pos + 1) % 48;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic gen_bit(output logic b);
    case (pat_sel)
      2'b00:   b = g[8] ^ g[10];
      2'b01:   b = g[13] ^ g[14];
      default: b = g[16] ^ g[19];
    endcase
    g = {g[18:0], b};
  endtask

  task automatic send_pn(input int n);
    logic b;
    for (int i = 0; i < n; i++) begin
      gen_bit(b);
      send_bit(b);
    end
  endtask

  task automatic send_pn_err();
    logic b;
    gen_bit(b);
    send_bit(~b);
  endtask

  task automatic align_to(input int p);
    while (pos != p) send_pn(1);
  endtask

  task automatic restart(input logic [1:0] sel);
    @(negedge clk);
    test_en = 1'b0;
    pat_sel = sel;
    @(negedge clk);
    test_en = 1'b1;
    g   = '1;
    pos = 0;
    #1;
  endtask

  task automatic strobe_clear(input logic ce, input logic cc);
    @(negedge clk);
    clr_err = ce;
    clr_chg = cc;
    @(posedge clk);
    #2;
    clr_err = 1'b0;
    clr_chg = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ready after reset", s_ready, 1);
    check("R1 sync after reset", in_sync, 0);
    check("R9 err_flag after reset", err_flag, 0);
    check("R8 chg_flag after reset", chg_flag, 0);
    check("R10 irq after reset", irq, 0);
  endtask

  task automatic t_zero_lock();
    restart(2'b00);
    for (int i = 0; i < 47; i++) begin
      send_bit(1'b0);
      idle(1);
    end
    check("R3 no sync after 47 matches with gaps", in_sync, 0);
    send_bit(1'b0);
    check("R3 sync on 48th match", in_sync, 1);
    check("R8 rise sets chg_flag", chg_flag, 1);
  endtask

  task automatic t_enable_low();
    strobe_clear(1'b0, 1'b1);
    check("R9 chg_flag cleared", chg_flag, 0);
    @(negedge clk);
    test_en = 1'b0;
    idle(1);
    check("R1 sync cleared when test_en low", in_sync, 0);
    check("R8 fall by test_en sets chg_flag", chg_flag, 1);
    pulses = 0;
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    check("R1 no pulses while disabled", pulses, 0);
    check("R1 still out of sync while disabled", in_sync, 0);
  endtask

  task automatic t_invert();
    restart(2'b00);
    rx_inv = 1'b1;
    for (int i = 0; i < 47; i++) send_bit(1'b1);
    check("R11 inverted ones: no sync at 47", in_sync, 0);
    send_bit(1'b1);
    check("R11 inverted ones: sync at 48", in_sync, 1);
    rx_inv = 1'b0;
  endtask

  task automatic t_no_lock();
    restart(2'b00);
    pulses = 0;
    for (int i = 0; i < 150; i++) send_bit(1'b1);
    check("R3 all ones never lock", in_sync, 0);
    check("R4 no pulses out of sync", pulses, 0);
  endtask

  task automatic t_patterns();
    for (int s = 0; s < 3; s++) begin
      restart(2'(s));
      send_pn(80);
      check($sformatf("R2 lock on pattern %0d", s), in_sync, 1);
      pulses = 0;
      send_pn(200);
      check($sformatf("R5 clean run pattern %0d pulses", s), pulses, 0);
      check($sformatf("R2 stays in sync pattern %0d", s), in_sync, 1);
    end
  endtask

  task automatic t_single_err();
    restart(2'b01);
    send_pn(80);
    check("R2 lock 15-bit pattern", in_sync, 1);
    strobe_clear(1'b1, 1'b1);
    pulses = 0;
    send_pn_err();
    check("R4 err_pulse on error bit", err_pulse, 1);
    check("R4 err_flag set", err_flag, 1);
    send_pn(1);
    check("R4 pulse lasts one cycle", err_pulse, 0);
    send_pn(100);
    check("R5 single error gives one event", pulses, 1);
    check("R5 sync kept", in_sync, 1);
  endtask

  task automatic t_window();
    align_to(0);
    align_to(38);
    pulses = 0;
    for (int i = 0; i < 10; i++) send_pn_err();
    check("R7 window end at position 0", pos, 0);
    for (int i = 0; i < 10; i++) send_pn_err();
    check("R7 ten plus ten across boundary keeps sync", in_sync, 1);
    check("R4 twenty pulses", pulses, 20);
    align_to(0);
    strobe_clear(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) begin
      send_pn_err();
      send_pn(1);
    end
    check("R6 ten errors in window keep sync", in_sync, 1);
    send_pn_err();
    check("R6 eleventh error drops sync", in_sync, 0);
    check("R6 eleventh error still pulses", err_pulse, 1);
    check("R8 fall sets chg_flag", chg_flag, 1);
    send_pn(47);
    check("R3 relock not before 48", in_sync, 0);
    send_pn(1);
    check("R3 relock at 48", in_sync, 1);
  endtask

  task automatic t_irq();
    strobe_clear(1'b1, 1'b1);
    check("R9 both flags clear", err_flag + chg_flag, 0);
    check("R10 irq low after clear", irq, 0);
    send_pn_err();
    check("R10 irq masked", irq, 0);
    err_irq_en = 1'b1;
    #1;
    check("R10 irq on enable", irq, 1);
    clr_err = 1'b1;
    send_pn_err();
    clr_err = 1'b0;
    check("R9 event wins over clear", err_flag, 1);
    strobe_clear(1'b1, 1'b0);
    check("R9 clear err_flag", err_flag, 0);
    check("R10 irq drops", irq, 0);
    chg_irq_en = 1'b1;
    @(negedge clk);
    test_en = 1'b0;
    idle(1);
    check("R10 irq from chg_flag", irq, 1);
    strobe_clear(1'b0, 1'b1);
    check("R10 irq after chg clear", irq, 0);
  endtask

  initial begin
    #3000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    g = '1;
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_zero_lock();
    t_enable_low();
    t_invert();
    t_no_lock();
    t_patterns();
    t_single_err();
    t_window();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule